// File: doc/BRIEF.md
# Multi-Channel DMA Controller

This block is a DMA engine with a few independent channels. Software programs each channel with a source address, a destination address, a word count and two flags. One flag marks the source as a fixed-address peripheral and the other marks the destination that way. A start bit then launches the channel. After that the channel moves the data by itself over one shared single-master bus. It uses its own read-side and write-side address counters and a private FIFO. When the last word is written, or when a bus error stops the channel, a status flag is set. An interrupt can be raised from those flags.

Every channel is a two-state sequencer, `CH_IDLE` and `CH_XFER`:
- `CH_IDLE` goes to `CH_XFER` on a start with a non-zero count.
- `CH_XFER` goes back to `CH_IDLE` on the acknowledge of the last write, or on any error response.

While in `CH_XFER`, a channel asks for a read whenever words remain to be fetched and its FIFO has room. Otherwise it asks to write the FIFO head.

A shared arbiter also has two states, `ARB_IDLE` and `ARB_WAIT`:
- `ARB_IDLE` goes to `ARB_WAIT` when any channel requests. It grants the first requester found after the channel served last.
- `ARB_WAIT` drives the granted request onto the bus. It goes back to `ARB_IDLE` on acknowledge or error.

Each grant moves exactly one word.

Top module: `dma_engine`

## Requirements
- R1: After reset, `bus_req` and `irq` are 0, every status bit reads 0 and every channel reads not busy.
- R2: `cfg_addr` is {block, index}, with the index in bits [1:0]. Blocks 0..NCH-1 are channels: index 0 is the source address, 1 the destination address, 2 the word count, and 3 the control register. In the control register, bit0 is written 1 to start and reads back as busy, bit1 marks a fixed source and bit2 marks a fixed destination. Block NCH index 0 is status, with done flags in bits [NCH-1:0] and error flags in bits [2NCH-1:NCH]. Block NCH index 1 is the interrupt enable in bit0.
- R3: A memory-side address advances by 4 after each beat, and a fixed (peripheral) address stays constant. The words arrive at the destination in source order in all four direction combinations.
- R4: A channel performs `count` reads and `count` writes. Its done flag is set on the acknowledge of the last write, and its busy bit then reads 0.
- R5: At most 4 words are held per channel. No read is issued while the FIFO is full, and a read is preferred whenever there is room. For a single 8-word transfer the bus therefore sees read, read, read, read, write, read.
- R6: Requesting channels are granted in round-robin order starting after the last channel served, one word per grant. Two continuously busy channels therefore alternate.
- R7: A bus request stays asserted with stable address, direction and write data until `bus_ack` or `bus_err` arrives.
- R8: A `bus_err` response stops the channel at once. It sets that channel's error flag, leaves the done flag clear, and no further bus access is made for that transfer.
- R9: `irq` is high exactly when the interrupt enable is set and any status flag is set. Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear.
- R10: Configuration writes to a channel that is busy, including a second start, have no effect.
- R11: A start with a count of 0 sets the done flag at once and makes no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NCH+1)+2 | Register address {block, index} |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer completed |
| bus_err | input | 1 | Transfer failed |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume the bus slave gives exactly one `bus_ack` or `bus_err` for each request, and only while `bus_req` is high. They also assume the slave never responds to an idle bus. The bench slave model answers one cycle after it sees a request and never earlier. Register writes and reads are driven on the falling edge, so they are always whole-cycle strobes. Error injection is limited to a single chosen address, so each run produces at most one error response.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic {CH_IDLE, CH_XFER} ch_state_e;
    typedef enum logic {ARB_IDLE, ARB_WAIT} arb_state_e;
    localparam logic [1:0] IDX_SRC  = 2'd0;
    localparam logic [1:0] IDX_DST  = 2'd1;
    localparam logic [1:0] IDX_CNT  = 2'd2;
    localparam logic [1:0] IDX_CTRL = 2'd3;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [DW-1:0] store_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [LW-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (push) store_q[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({push, pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    assign dout  = store_q[rd_q];
    assign full  = (lvl_q == LW'(DEPTH));
    assign empty = (lvl_q == '0);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flush |-> !push || pop);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CW    = 8,
    parameter int FDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_idx,
    input  logic [AW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    input  logic          ack_i,
    input  logic          err_i,
    input  logic [DW-1:0] rdata_i,
    output logic          done_o,
    output logic          fault_o
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    ch_state_e     state_q, state_d;
    logic [AW-1:0] src_q, dst_q, rd_addr_q, wr_addr_q;
    logic [CW-1:0] cnt_q, rd_left_q, wr_left_q;
    logic          src_fix_q, dst_fix_q;
    logic          fifo_full, fifo_empty, rd_ok, last_wr;
    logic          start_go, start_zero, idle_wr;

    assign idle_wr    = cfg_we && (state_q == CH_IDLE);
    assign start_go   = idle_wr && cfg_idx == IDX_CTRL && cfg_wdata[0] && cnt_q != '0;
    assign start_zero = idle_wr && cfg_idx == IDX_CTRL && cfg_wdata[0] && cnt_q == '0;
    assign last_wr    = ack_i && we_o && wr_left_q == CW'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (start_go) state_d = CH_XFER;
            CH_XFER: if (err_i || last_wr) state_d = CH_IDLE;
        endcase
    end

    // configuration and address counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; cnt_q <= '0;
            src_fix_q <= 1'b0; dst_fix_q <= 1'b0;
            rd_addr_q <= '0; wr_addr_q <= '0;
            rd_left_q <= '0; wr_left_q <= '0;
        end else begin
            if (idle_wr) begin
                unique case (cfg_idx)
                    IDX_SRC: src_q <= cfg_wdata;
                    IDX_DST: dst_q <= cfg_wdata;
                    IDX_CNT: cnt_q <= cfg_wdata[CW-1:0];
                    IDX_CTRL: begin
                        src_fix_q <= cfg_wdata[1];
                        dst_fix_q <= cfg_wdata[2];
                    end
                endcase
            end
            if (start_go) begin
                rd_addr_q <= src_q;
                wr_addr_q <= dst_q;
                rd_left_q <= cnt_q;
                wr_left_q <= cnt_q;
            end
            if (ack_i && state_q == CH_XFER) begin
                if (we_o) begin
                    if (!dst_fix_q) wr_addr_q <= wr_addr_q + STEP;
                    wr_left_q <= wr_left_q - 1'b1;
                end else begin
                    if (!src_fix_q) rd_addr_q <= rd_addr_q + STEP;
                    rd_left_q <= rd_left_q - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rd_ok   = (rd_left_q != '0) && !fifo_full;
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = rd_addr_q;
        done_o  = start_zero;
        fault_o = 1'b0;
        unique case (state_q)
            CH_IDLE: ;
            CH_XFER: begin
                req_o   = rd_ok || !fifo_empty;
                we_o    = !rd_ok;
                addr_o  = rd_ok ? rd_addr_q : wr_addr_q;
                done_o  = last_wr;
                fault_o = err_i;
            end
        endcase
    end

    always_comb begin
        unique case (cfg_idx)
            IDX_SRC: cfg_rdata = DW'(src_q);
            IDX_DST: cfg_rdata = DW'(dst_q);
            IDX_CNT: cfg_rdata = DW'(cnt_q);
            default: cfg_rdata = DW'({dst_fix_q, src_fix_q, state_q == CH_XFER});
        endcase
    end

    dma_fifo #(.DW(DW), .DEPTH(FDEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (err_i),
        .push  (ack_i && !we_o && state_q == CH_XFER),
        .pop   (ack_i && we_o && state_q == CH_XFER),
        .din   (rdata_i),
        .dout  (wdata_o),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CH_IDLE |-> !req_o);
    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> state_q == CH_IDLE && !req_o);
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 16,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          req_i,
    input  logic [NCH-1:0]          we_i,
    input  logic [NCH-1:0][AW-1:0]  addr_i,
    input  logic [NCH-1:0][DW-1:0]  wdata_i,
    output logic [NCH-1:0]          ack_o,
    output logic [NCH-1:0]          err_o,
    output logic                    bus_req_o,
    output logic                    bus_we_o,
    output logic [AW-1:0]           bus_addr_o,
    output logic [DW-1:0]           bus_wdata_o,
    input  logic                    bus_ack_i,
    input  logic                    bus_err_i
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    arb_state_e     state_q, state_d;
    logic [CHW-1:0] grant_q, last_q, pick;
    logic           found;

    always_comb begin
        pick  = last_q;
        found = 1'b0;
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NCH;
            if (!found && req_i[idx]) begin
                pick  = CHW'(idx);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            last_q  <= CHW'(NCH - 1);
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && found) grant_q <= pick;
            if (state_q == ARB_WAIT && (bus_ack_i || bus_err_i)) last_q <= grant_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (found) state_d = ARB_WAIT;
            ARB_WAIT: if (bus_ack_i || bus_err_i) state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = we_i[grant_q];
        bus_addr_o  = addr_i[grant_q];
        bus_wdata_o = wdata_i[grant_q];
        ack_o       = '0;
        err_o       = '0;
        unique case (state_q)
            ARB_IDLE: ;
            ARB_WAIT: begin
                bus_req_o      = 1'b1;
                ack_o[grant_q] = bus_ack_i;
                err_o[grant_q] = bus_err_i;
            end
        endcase
    end

    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i && !bus_err_i |=>
        bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o));
    // R6
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> req_i[grant_q]);
    // R6
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o | err_o));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int NCH    = 2,
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int CW     = 8,
    parameter int FDEPTH = 4,
    parameter int BLKW   = $clog2(NCH + 1),
    parameter int RAW    = BLKW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ack,
    input  logic           bus_err,
    output logic           irq
);
    logic [BLKW-1:0]          blk;
    logic [1:0]               idx;
    logic [NCH-1:0]           ch_req, ch_we, ch_ack, ch_err, done_p, fault_p;
    logic [NCH-1:0][AW-1:0]   ch_addr;
    logic [NCH-1:0][DW-1:0]   ch_wdata, ch_rdata;
    logic [NCH-1:0]           done_q, err_q;
    logic                     irq_en_q, stat_wr;

    assign blk     = cfg_addr[RAW-1:2];
    assign idx     = cfg_addr[1:0];
    assign stat_wr = cfg_we && blk == BLKW'(NCH) && idx == 2'd0;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_channel #(.AW(AW), .DW(DW), .CW(CW), .FDEPTH(FDEPTH)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && blk == BLKW'(g)),
            .cfg_idx   (idx),
            .cfg_wdata (cfg_wdata[AW-1:0]),
            .cfg_rdata (ch_rdata[g]),
            .req_o     (ch_req[g]),
            .we_o      (ch_we[g]),
            .addr_o    (ch_addr[g]),
            .wdata_o   (ch_wdata[g]),
            .ack_i     (ch_ack[g]),
            .err_i     (ch_err[g]),
            .rdata_i   (bus_rdata),
            .done_o    (done_p[g]),
            .fault_o   (fault_p[g])
        );
    end

    dma_arbiter #(.NCH(NCH), .AW(AW), .DW(DW)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (ch_req),
        .we_i        (ch_we),
        .addr_i      (ch_addr),
        .wdata_i     (ch_wdata),
        .ack_o       (ch_ack),
        .err_o       (ch_err),
        .bus_req_o   (bus_req),
        .bus_we_o    (bus_we),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_ack_i   (bus_ack),
        .bus_err_i   (bus_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= '0;
            err_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            done_q <= (stat_wr ? (done_q & ~cfg_wdata[NCH-1:0]) : done_q) | done_p;
            err_q  <= (stat_wr ? (err_q & ~cfg_wdata[2*NCH-1:NCH]) : err_q) | fault_p;
            if (cfg_we && blk == BLKW'(NCH) && idx == 2'd1) irq_en_q <= cfg_wdata[0];
        end
    end

    assign irq = irq_en_q && (|done_q || |err_q);

    always_comb begin
        cfg_rdata = '0;
        for (int g = 0; g < NCH; g++) begin
            if (blk == BLKW'(g)) cfg_rdata = ch_rdata[g];
        end
        if (blk == BLKW'(NCH)) begin
            if (idx == 2'd0)      cfg_rdata = DW'({err_q, done_q});
            else if (idx == 2'd1) cfg_rdata = DW'(irq_en_q);
        end
    end

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && cfg_wdata[0] && !done_p[0] |=> !done_q[0]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_p[0] |=> done_q[0]);
endmodule

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        bus_req, bus_we, bus_ack, bus_err, irq;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [256];
    logic [31:0] periph_n;
    logic [15:0] err_addr;
    logic        err_en;

    typedef struct { logic [15:0] a; logic [31:0] d; } exp_t;
    exp_t exp_q0[$];
    exp_t exp_q1[$];
    logic        lg_we[$];
    logic [15:0] lg_addr[$];
    logic        lg_err[$];

    always #2 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [3:0] ra(input int b, input int i);
        return 4'(b * 4 + i);
    endfunction

    // bus slave: answers one cycle after the request
    initial begin
        bus_ack = 0; bus_err = 0; bus_rdata = '0; periph_n = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i * 7);
        forever begin
            @(posedge clk);
            if (bus_req && !bus_ack && !bus_err) begin
                if (err_en && bus_addr == err_addr) bus_err <= 1'b1;
                else begin
                    bus_ack <= 1'b1;
                    if (!bus_we) begin
                        if (bus_addr >= 16'h8000) begin
                            bus_rdata <= 32'hA000_0000 + periph_n;
                            periph_n  <= periph_n + 1;
                        end else bus_rdata <= mem[bus_addr[9:2]];
                    end
                end
            end else begin
                if (bus_ack && bus_we && bus_addr < 16'h8000) mem[bus_addr[9:2]] <= bus_wdata;
                bus_ack <= 1'b0;
                bus_err <= 1'b0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req && (bus_ack || bus_err)) begin
                lg_we.push_back(bus_we);
                lg_addr.push_back(bus_addr);
                lg_err.push_back(bus_err);
                if (bus_ack && bus_we) begin
                    if (exp_q0.size() > 0 && exp_q0[0].a == bus_addr) begin
                        check(bus_wdata == exp_q0[0].d, "R3 ch0 write data", bus_wdata, exp_q0[0].d);
                        void'(exp_q0.pop_front());
                    end else if (exp_q1.size() > 0 && exp_q1[0].a == bus_addr) begin
                        check(bus_wdata == exp_q1[0].d, "R3 ch1 write data", bus_wdata, exp_q1[0].d);
                        void'(exp_q1.pop_front());
                    end else
                        check(1'b0, "R3 unexpected write addr", 32'(bus_addr), 32'hFFFF_FFFF);
                end
            end
        end
    end

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // driver: programs a channel and pushes expected writes
    task automatic prog(input int ch, input logic [15:0] src, input logic [15:0] dst,
                        input int n, input bit sf, input bit df);
        cfg_write(ra(ch, 0), 32'(src));
        cfg_write(ra(ch, 1), 32'(dst));
        cfg_write(ra(ch, 2), 32'(n));
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = df ? dst : dst + 16'(4 * i);
            e.d = sf ? 32'hA000_0000 + periph_n + 32'(i) : mem[8'(src[9:2] + 8'(i))];
            if (ch == 0) exp_q0.push_back(e); else exp_q1.push_back(e);
        end
    endtask

    task automatic start(input int ch, input bit sf, input bit df);
        cfg_write(ra(ch, 3), {29'b0, df, sf, 1'b1});
    endtask

    task automatic wait_idle(input int ch);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            cfg_read(ra(ch, 3), v);
            if (!v[0]) break;
        end
    endtask

    task automatic clear_log();
        lg_we.delete(); lg_addr.delete(); lg_err.delete();
    endtask

    task automatic run_xfer(input int ch, input logic [15:0] src, input logic [15:0] dst,
                            input int n, input bit sf, input bit df);
        logic [31:0] v;
        int rd;
        clear_log();
        prog(ch, src, dst, n, sf, df);
        start(ch, sf, df);
        wait_idle(ch);
        check(lg_we.size() == 2 * n, "R4 beat count", 32'(lg_we.size()), 32'(2 * n));
        rd = 0;
        for (int k = 0; k < lg_we.size(); k++) begin
            if (!lg_we[k]) begin
                logic [15:0] ea;
                ea = sf ? src : src + 16'(4 * rd);
                check(lg_addr[k] == ea, "R3 read address", 32'(lg_addr[k]), 32'(ea));
                rd++;
            end
        end
        check((ch == 0 ? exp_q0.size() : exp_q1.size()) == 0, "R3 all writes seen", 32'(ch), 0);
        cfg_read(ra(2, 0), v);
        check(v[ch] == 1'b1 && v[2 + ch] == 1'b0, "R4 done flag", v, 32'(1 << ch));
        cfg_write(ra(2, 0), 32'hF);
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        err_en = 0; err_addr = '0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        @(negedge clk);
        check(bus_req == 0, "R1 bus_req", 32'(bus_req), 0);
        check(irq == 0, "R1 irq", 32'(irq), 0);
        cfg_read(ra(2, 0), v);
        check(v == 0, "R1 status", v, 0);
        cfg_read(ra(0, 3), v);
        check(v[0] == 0, "R1 busy", v, 0);

        // R2 register readback
        cfg_write(ra(1, 0), 32'h0123);
        cfg_read(ra(1, 0), v);
        check(v == 32'h0123, "R2 src readback", v, 32'h0123);

        cfg_write(ra(2, 1), 32'h1);

        // R3/R4 all four directions
        run_xfer(0, 16'h0000, 16'h0200, 4, 0, 0);
        run_xfer(1, 16'h8000, 16'h0300, 3, 1, 0);
        run_xfer(0, 16'h0010, 16'h8004, 3, 0, 1);
        run_xfer(1, 16'h8008, 16'h800C, 2, 1, 1);

        // R5 FIFO fill order
        run_xfer(0, 16'h0040, 16'h0240, 8, 0, 0);
        begin
            logic [5:0] got;
            for (int k = 0; k < 6; k++) got[k] = lg_we[k];
            check(got == 6'b010000, "R5 read/write order", 32'(got), 32'h10);
        end

        // R6 round robin between two channels
        clear_log();
        prog(0, 16'h0080, 16'h0280, 4, 0, 0);
        prog(1, 16'h0180, 16'h0380, 4, 0, 0);
        start(0, 0, 0);
        start(1, 0, 0);
        wait_idle(0);
        wait_idle(1);
        begin
            logic [5:0] got;
            for (int k = 0; k < 6; k++) got[k] = lg_addr[k][8];
            check(got == 6'b101010, "R6 alternation", 32'(got), 32'h2A);
        end
        check(exp_q0.size() == 0 && exp_q1.size() == 0, "R6 both complete", 0, 0);
        cfg_write(ra(2, 0), 32'hF);

        // R10 writes while busy ignored
        prog(0, 16'h00A0, 16'h02A0, 8, 0, 0);
        start(0, 0, 0);
        cfg_write(ra(0, 0), 32'h0444);
        cfg_read(ra(0, 0), v);
        check(v == 32'h00A0, "R10 src unchanged", v, 32'h00A0);
        wait_idle(0);
        check(exp_q0.size() == 0, "R10 transfer intact", 32'(exp_q0.size()), 0);
        cfg_write(ra(2, 0), 32'hF);

        // R8 bus error
        clear_log();
        err_en = 1; err_addr = 16'h0128;
        cfg_write(ra(1, 0), 32'h0120);
        cfg_write(ra(1, 1), 32'h0320);
        cfg_write(ra(1, 2), 32'd4);
        start(1, 0, 0);
        wait_idle(1);
        repeat (10) @(negedge clk);
        check(lg_we.size() == 3 && lg_err[2] == 1, "R8 stop after error", 32'(lg_we.size()), 3);
        cfg_read(ra(2, 0), v);
        check(v[3] == 1 && v[1] == 0, "R8 error flag", v, 32'h8);
        check(irq == 1, "R9 irq on error", 32'(irq), 1);
        err_en = 0;
        cfg_write(ra(2, 0), 32'hF);
        @(negedge clk);
        check(irq == 0, "R9 cleared by w1c", 32'(irq), 0);

        // R11 zero count
        clear_log();
        cfg_write(ra(0, 2), 32'd0);
        start(0, 0, 0);
        cfg_read(ra(2, 0), v);
        check(v[0] == 1, "R11 done at once", v, 1);
        repeat (5) @(negedge clk);
        check(lg_we.size() == 0, "R11 no bus access", 32'(lg_we.size()), 0);

        // R9 enable gating
        cfg_write(ra(2, 1), 32'h0);
        @(negedge clk);
        check(irq == 0, "R9 disabled", 32'(irq), 0);
        cfg_write(ra(2, 1), 32'h1);
        @(negedge clk);
        check(irq == 1, "R9 enabled", 32'(irq), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule